// File: doc/BRIEF.md
# Four-Channel Peripheral Byte Mover

This block moves bytes between a flat 64 KiB external RAM and four fixed peripheral data ports. Three of the ports take data from RAM: a key port, a block-input port and an XOR-input port. The fourth port is an output port whose bytes are written back to RAM. There are four channels. Each channel holds its own route code, its own wrap mode, and a 16-bit base address, size and running offset. The RAM address of a channel is always base plus offset.

Software programs the channels one at a time through a shared register window. A select register chooses which channel's registers appear in the window. A global enable register starts the channels, and a flag register records which channels have completed. A peripheral raises its request line while it can accept or supply a byte. A fixed round-robin arbiter grants one RAM access per cycle, and the granted port receives an acknowledge in that same cycle.

A wrapping channel sends a short buffer, such as a key, again and again. A linear channel stops once it has moved its whole buffer.

Top module: `pdma_engine`

## Requirements
- R1: After reset, every register reads as zero, `ram_req` is low, `port_ack` is zero and `irq` is low.
- R2: Address 0 holds the select register. Address 1 holds the enable register and address 2 the flag register. Addresses 3 to 10 show the selected channel's registers: 3 is the route code (bit 7 is the interrupt enable), 4 is the mode (bit 0 is wrap), 5/6 are the base low/high bytes, 7/8 are the size low/high bytes and 9/10 are the offset low/high bytes. `reg_rdata` returns the addressed register combinationally.
- R3: Bits 6:0 of the route code choose the port and the direction. 0x05 moves RAM to port 0, 0x06 moves RAM to port 1, 0x07 moves RAM to port 2, and 0x08 moves port 3 to RAM. A channel with any other code never transfers.
- R4: A channel transfers when all four of these hold: it is enabled, its code is valid, its port's request is high, and its offset differs from its size. It then moves one byte per grant. `ram_addr` is base+offset. For a RAM-to-port transfer, `port_wdata` equals `ram_rdata`. For a port-to-RAM transfer, `ram_we` is high and `ram_wdata` equals `out_rdata`. The offset then increments.
- R5: When a non-wrapping channel moves its last byte, it sets its flag bit and clears its enable bit, and its offset reads back equal to its size.
- R6: A wrapping channel resets its offset to zero after its last byte. It stays enabled and never sets its flag.
- R7: At most one `port_ack` bit is high per cycle, and `ram_req` is high exactly when one is. Contending channels are served in round-robin order, starting from channel 0 after reset.
- R8: A write to the window while the selected channel is enabled is ignored.
- R9: Writing 0x00 to the enable register disables all channels, and no transfer happens in the following cycle.
- R10: Writing a 0 to a bit of the flag register clears that flag. Writing a 1 leaves the bit unchanged. A completion in the same cycle as the write wins.
- R11: `irq` is high exactly when some channel has both its flag set and bit 7 of its route code set.
- R12: A channel with size zero never transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ram_req | output | 1 | RAM access this cycle |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, same cycle |
| port_req | input | 4 | Per-port request (0 key, 1 block in, 2 XOR in, 3 output) |
| port_ack | output | 4 | Per-port acknowledge |
| port_wdata | output | 8 | Byte delivered to the acknowledged input port |
| out_rdata | input | 8 | Byte offered by the output port |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with its default of four channels, so every port and every route code can be reached. A channel can wrap while the other three complete around it. Random per-port requests let all four channels contend at once, which exercises the round-robin rotation and completions that coincide with software writes. Short sizes (16 and 40 bytes) reach wrap and completion within a few hundred cycles.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int NPORT  = 4;
    localparam int RAW    = 4;

    localparam logic [RAW-1:0] RA_SEL   = 4'd0;
    localparam logic [RAW-1:0] RA_EN    = 4'd1;
    localparam logic [RAW-1:0] RA_FLAG  = 4'd2;
    localparam logic [RAW-1:0] RA_CFG   = 4'd3;
    localparam logic [RAW-1:0] RA_MODE  = 4'd4;
    localparam logic [RAW-1:0] RA_BASEL = 4'd5;
    localparam logic [RAW-1:0] RA_BASEH = 4'd6;
    localparam logic [RAW-1:0] RA_SIZEL = 4'd7;
    localparam logic [RAW-1:0] RA_SIZEH = 4'd8;
    localparam logic [RAW-1:0] RA_OFFL  = 4'd9;
    localparam logic [RAW-1:0] RA_OFFH  = 4'd10;

    typedef enum logic [1:0] {
        P_KEY = 2'd0,
        P_BLK = 2'd1,
        P_XOR = 2'd2,
        P_OUT = 2'd3
    } port_e;

    typedef struct packed {
        logic  valid;
        logic  to_ram;
        port_e port;
    } route_t;

    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic              wrap;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] size;
        logic [ADDR_W-1:0] off;
    } chan_view_t;

    function automatic route_t decode_route(input logic [6:0] code);
        route_t r;
        r = '{valid: 1'b1, to_ram: 1'b0, port: P_KEY};
        case (code)
            7'h05: r.port = P_KEY;
            7'h06: r.port = P_BLK;
            7'h07: r.port = P_XOR;
            7'h08: begin r.port = P_OUT; r.to_ram = 1'b1; end
            default: r.valid = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic in_window(input logic [RAW-1:0] a);
        return (a >= RA_CFG) && (a <= RA_OFFH);
    endfunction

endpackage

// File: rtl/pdma_arbiter.sv
module pdma_arbiter #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gidx,
    output logic          any
);
    logic [IW-1:0] last_q;
    int            cand;

    always_comb begin
        any  = 1'b0;
        gidx = '0;
        cand = 0;
        for (int i = 1; i <= N; i++) begin
            cand = (int'(last_q) + i) % N;
            if (!any && req[cand]) begin
                any  = 1'b1;
                gidx = IW'(cand);
            end
        end
        gnt = any ? (N'(1) << gidx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= IW'(N - 1);
        else if (any)
            last_q <= gidx;
    end
endmodule

// File: rtl/pdma_chan.sv
module pdma_chan
    import pdma_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 win_we,
    input  logic [RAW-1:0]       win_addr,
    input  logic [DATA_W-1:0]    win_wdata,
    input  logic                 ch_en,
    input  logic [NPORT-1:0]     port_req,
    input  logic                 grant,
    output chan_view_t           view,
    output route_t               route,
    output logic                 want,
    output logic                 done
);
    logic [DATA_W-1:0] cfg_q;
    logic              wrap_q;
    logic [ADDR_W-1:0] base_q, size_q, off_q;
    logic              last_byte;

    assign route     = decode_route(cfg_q[6:0]);
    assign last_byte = (off_q + ADDR_W'(1)) == size_q;
    assign want      = ch_en && route.valid && (off_q != size_q) && port_req[route.port];
    assign done      = grant && last_byte && !wrap_q;
    assign view      = '{cfg: cfg_q, wrap: wrap_q, base: base_q, size: size_q, off: off_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            wrap_q <= 1'b0;
            base_q <= '0;
            size_q <= '0;
            off_q  <= '0;
        end else if (win_we) begin
            case (win_addr)
                RA_CFG:   cfg_q         <= win_wdata;
                RA_MODE:  wrap_q        <= win_wdata[0];
                RA_BASEL: base_q[7:0]   <= win_wdata;
                RA_BASEH: base_q[15:8]  <= win_wdata;
                RA_SIZEL: size_q[7:0]   <= win_wdata;
                RA_SIZEH: size_q[15:8]  <= win_wdata;
                RA_OFFL:  off_q[7:0]    <= win_wdata;
                RA_OFFH:  off_q[15:8]   <= win_wdata;
                default: ;
            endcase
        end else if (grant) begin
            if (last_byte)
                off_q <= wrap_q ? '0 : size_q;
            else
                off_q <= off_q + ADDR_W'(1);
        end
    end
endmodule

// File: rtl/pdma_engine.sv
module pdma_engine
    import pdma_pkg::*;
#(
    parameter int NCH = 4,
    localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        ram_req,
    output logic        ram_we,
    output logic [15:0] ram_addr,
    output logic [7:0]  ram_wdata,
    input  logic [7:0]  ram_rdata,
    input  logic [3:0]  port_req,
    output logic [3:0]  port_ack,
    output logic [7:0]  port_wdata,
    input  logic [7:0]  out_rdata,
    output logic        irq
);
    logic [SELW-1:0] sel_q;
    logic [NCH-1:0]  en_q, en_d;
    logic [NCH-1:0]  flag_q, flag_d;
    logic [NCH-1:0]  want, done, gnt, ie;
    logic [SELW-1:0] gidx;
    logic            any;
    chan_view_t      view [NCH];
    route_t          rt   [NCH];
    route_t          rt_g;
    chan_view_t      vw_g;
    chan_view_t      vw_s;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic win_we_c;
        assign win_we_c = reg_we && in_window(reg_addr) &&
                          (sel_q == SELW'(c)) && !en_q[c];
        assign ie[c] = view[c].cfg[7];

        pdma_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .win_we    (win_we_c),
            .win_addr  (reg_addr),
            .win_wdata (reg_wdata),
            .ch_en     (en_q[c]),
            .port_req  (port_req),
            .grant     (gnt[c]),
            .view      (view[c]),
            .route     (rt[c]),
            .want      (want[c]),
            .done      (done[c])
        );
    end

    pdma_arbiter #(.N(NCH)) u_arb (
        .clk  (clk),
        .rst  (rst),
        .req  (want),
        .gnt  (gnt),
        .gidx (gidx),
        .any  (any)
    );

    assign rt_g = rt[gidx];
    assign vw_g = view[gidx];
    assign vw_s = view[sel_q];

    always_comb begin
        ram_req    = any;
        ram_addr   = any ? (vw_g.base + vw_g.off) : '0;
        ram_we     = any && rt_g.to_ram;
        ram_wdata  = (any && rt_g.to_ram) ? out_rdata : '0;
        port_wdata = (any && !rt_g.to_ram) ? ram_rdata : '0;
        port_ack   = '0;
        if (any)
            port_ack[rt_g.port] = 1'b1;
    end

    always_comb begin
        en_d = en_q;
        if (reg_we && reg_addr == RA_EN)
            en_d = reg_wdata[NCH-1:0];
        en_d = en_d & ~done;
        flag_d = flag_q;
        if (reg_we && reg_addr == RA_FLAG)
            flag_d = flag_d & reg_wdata[NCH-1:0];
        flag_d = flag_d | done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            en_q   <= '0;
            flag_q <= '0;
        end else begin
            if (reg_we && reg_addr == RA_SEL)
                sel_q <= reg_wdata[SELW-1:0];
            en_q   <= en_d;
            flag_q <= flag_d;
        end
    end

    assign irq = |(flag_q & ie);

    always_comb begin
        case (reg_addr)
            RA_SEL:   reg_rdata = 8'(sel_q);
            RA_EN:    reg_rdata = 8'(en_q);
            RA_FLAG:  reg_rdata = 8'(flag_q);
            RA_CFG:   reg_rdata = vw_s.cfg;
            RA_MODE:  reg_rdata = {7'b0, vw_s.wrap};
            RA_BASEL: reg_rdata = vw_s.base[7:0];
            RA_BASEH: reg_rdata = vw_s.base[15:8];
            RA_SIZEL: reg_rdata = vw_s.size[7:0];
            RA_SIZEH: reg_rdata = vw_s.size[15:8];
            RA_OFFL:  reg_rdata = vw_s.off[7:0];
            RA_OFFH:  reg_rdata = vw_s.off[15:8];
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pdma_engine_chk.sv
module pdma_engine_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           reg_we,
    input logic [3:0]     reg_addr,
    input logic [7:0]     reg_wdata,
    input logic           ram_req,
    input logic           ram_we,
    input logic [3:0]     port_req,
    input logic [3:0]     port_ack,
    input logic           irq,
    input logic [NCH-1:0] en_q,
    input logic [NCH-1:0] flag_q
);
    assert_one_access_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(port_ack) && (ram_req == (port_ack != 4'b0)));

    assert_ack_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
        (port_ack != 4'b0) |-> ((port_ack & port_req) == port_ack));

    assert_write_only_output_R3: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> port_ack[3]);

    assert_irq_has_flag_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag_q != '0));

    assert_disable_all_R9: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 4'd1 && reg_wdata == 8'h00) |=> (en_q == '0 && !ram_req));

    for (genvar c = 0; c < NCH; c++) begin : g_c
        assert_done_stops_R5: assert property (@(posedge clk) disable iff (rst)
            $rose(flag_q[c]) |-> !en_q[c]);
    end
endmodule

bind pdma_engine pdma_engine_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ram_req   (ram_req),
    .ram_we    (ram_we),
    .port_req  (port_req),
    .port_ack  (port_ack),
    .irq       (irq),
    .en_q      (en_q),
    .flag_q    (flag_q)
);

// File: tb/test_pdma_engine.sv
`timescale 1ns/1ps
module test_pdma_engine;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        ram_req, ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata, ram_rdata;
    logic [3:0]  port_req = '0;
    logic [3:0]  port_ack;
    logic [7:0]  port_wdata;
    logic [7:0]  out_rdata = '0;
    logic        irq;

    logic [7:0] mem [65536];
    assign ram_rdata = mem[ram_addr];

    pdma_engine i_pdma_engine (.*);

    always #2 clk = ~clk;

    int errors = 0, checks = 0, cycles = 0;
    bit rand_mode = 0;

    // behavioural model state
    int msel, mlast;
    int men[4], mfl[4], mcfg[4], mwrap[4], mbase[4], msize[4], moff[4];
    // expected outputs
    int e_g, e_addr, e_we, e_wdata, e_ack, e_pwdata, e_irq, e_rdata, e_req;

    function automatic int portof(int cfg);
        case (cfg & 8'h7F)
            8'h05: return 0;
            8'h06: return 1;
            8'h07: return 2;
            8'h08: return 3;
            default: return -1;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic eval();
        int c, p;
        e_g = -1; e_addr = 0; e_we = 0; e_wdata = 0; e_ack = 0; e_pwdata = 0;
        for (int i = 1; i <= 4; i++) begin
            c = (mlast + i) % 4;
            p = portof(mcfg[c]);
            if (e_g < 0 && men[c] != 0 && p >= 0 && moff[c] != msize[c] && port_req[p])
                e_g = c;
        end
        e_req = (e_g >= 0);
        if (e_g >= 0) begin
            p = portof(mcfg[e_g]);
            e_addr = (mbase[e_g] + moff[e_g]) & 16'hFFFF;
            e_ack = 1 << p;
            if (p == 3) begin e_we = 1; e_wdata = out_rdata; end
            else e_pwdata = mem[e_addr];
        end
        e_irq = 0;
        for (int k = 0; k < 4; k++)
            if (mfl[k] != 0 && mcfg[k][7]) e_irq = 1;
        case (reg_addr)
            0: e_rdata = msel;
            1: e_rdata = men[0] | (men[1] << 1) | (men[2] << 2) | (men[3] << 3);
            2: e_rdata = mfl[0] | (mfl[1] << 1) | (mfl[2] << 2) | (mfl[3] << 3);
            3: e_rdata = mcfg[msel];
            4: e_rdata = mwrap[msel];
            5: e_rdata = mbase[msel] & 8'hFF;
            6: e_rdata = mbase[msel] >> 8;
            7: e_rdata = msize[msel] & 8'hFF;
            8: e_rdata = msize[msel] >> 8;
            9: e_rdata = moff[msel] & 8'hFF;
            10: e_rdata = moff[msel] >> 8;
            default: e_rdata = 0;
        endcase
    endtask

    // model update at each edge (uses bench state and stable inputs only)
    always @(posedge clk) begin
        if (rst) begin
            msel = 0; mlast = 3;
            for (int k = 0; k < 4; k++) begin
                men[k] = 0; mfl[k] = 0; mcfg[k] = 0; mwrap[k] = 0;
                mbase[k] = 0; msize[k] = 0; moff[k] = 0;
            end
        end else begin
            int w, g, lastb, oen;
            eval();
            g = e_g;
            if (e_we) mem[e_addr] = 8'(e_wdata);
            oen = men[msel];
            w = reg_wdata;
            if (reg_we) begin
                case (reg_addr)
                    0: msel = w & 3;
                    1: for (int k = 0; k < 4; k++) men[k] = (w >> k) & 1;
                    2: for (int k = 0; k < 4; k++) mfl[k] = mfl[k] & ((w >> k) & 1);
                    default: if (reg_addr >= 3 && reg_addr <= 10 && oen == 0) begin
                        case (reg_addr)
                            3: mcfg[msel] = w;
                            4: mwrap[msel] = w & 1;
                            5: mbase[msel] = (mbase[msel] & 16'hFF00) | w;
                            6: mbase[msel] = (mbase[msel] & 16'h00FF) | (w << 8);
                            7: msize[msel] = (msize[msel] & 16'hFF00) | w;
                            8: msize[msel] = (msize[msel] & 16'h00FF) | (w << 8);
                            9: moff[msel] = (moff[msel] & 16'hFF00) | w;
                            10: moff[msel] = (moff[msel] & 16'h00FF) | (w << 8);
                            default: ;
                        endcase
                    end
                endcase
            end
            if (g >= 0) begin
                mlast = g;
                lastb = (((moff[g] + 1) & 16'hFFFF) == msize[g]);
                if (!lastb) moff[g] = (moff[g] + 1) & 16'hFFFF;
                else if (mwrap[g]) moff[g] = 0;
                else begin moff[g] = msize[g]; mfl[g] = 1; men[g] = 0; end
            end
        end
    end

    // per-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            eval();
            check("R7 ram_req", ram_req, e_req);
            check("R7 port_ack", port_ack, e_ack);
            check("R4 ram_addr", ram_addr, e_addr);
            check("R4 ram_we", ram_we, e_we);
            check("R4 ram_wdata", ram_wdata, e_wdata);
            check("R4 port_wdata", port_wdata, e_pwdata);
            check("R11 irq", irq, e_irq);
            check("R2 reg_rdata", reg_rdata, e_rdata);
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    always @(posedge clk) begin
        #1;
        if (rand_mode) begin
            port_req  = 4'($urandom);
            out_rdata = 8'($urandom);
        end
    end

    task automatic wr(int a, int d);
        reg_we = 1; reg_addr = 4'(a); reg_wdata = 8'(d);
        @(posedge clk); #1;
        reg_we = 0;
    endtask

    task automatic rd(int a, int exp, string tag);
        reg_addr = 4'(a);
        @(negedge clk);
        check(tag, reg_rdata, exp);
        @(posedge clk); #1;
    endtask

    task automatic prog(int ch, int cfg, int wrap, int base, int size);
        wr(0, ch); wr(3, cfg); wr(4, wrap);
        wr(5, base & 255); wr(6, base >> 8);
        wr(7, size & 255); wr(8, size >> 8);
        wr(9, 0); wr(10, 0);
    endtask

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    int nreq, prevp, curp;

    initial begin
        for (int i = 0; i < 65536; i++) mem[i] = 8'(i ^ (i >> 8));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        for (int a = 0; a <= 10; a++) rd(a, 0, "R1 reset register");
        check("R1 irq after reset", irq, 0);
        check("R1 no access after reset", ram_req, 0);

        prog(0, 8'h05, 1, 16'h1000, 16);
        prog(1, 8'h86, 0, 16'h2000, 40);
        prog(2, 8'h07, 0, 16'h3000, 40);
        prog(3, 8'h88, 0, 16'h4000, 40);
        rd(6, 8'h40, "R2 base high of selected channel");
        rand_mode = 1;
        wr(1, 8'h0F);
        for (int t = 0; t < 3000; t++) begin
            if (mfl[1] && mfl[2] && mfl[3]) break;
            idle(1);
        end
        rand_mode = 0; port_req = '0;
        idle(1);
        rd(2, 8'h0E, "R5 flags of completed channels");
        rd(1, 8'h01, "R6 wrapping channel still enabled");
        check("R11 irq with enabled flags", irq, 1);
        rd(9, 40, "R5 offset held at size");
        wr(0, 0);
        reg_addr = 9;
        @(negedge clk);
        check("R6 wrap offset below size", (reg_rdata < 16), 1);
        @(posedge clk); #1;

        // R8 window locked while enabled
        wr(3, 8'h07);
        rd(3, 8'h05, "R8 write to running channel ignored");

        // R10 flag clearing
        wr(2, 8'hFD);
        rd(2, 8'h0C, "R10 clear one flag");
        check("R11 irq from channel 3", irq, 1);
        wr(2, 8'h00);
        rd(2, 8'h00, "R10 clear all flags");
        check("R11 irq cleared", irq, 0);

        // R9 disable all
        port_req = 4'hF;
        wr(1, 8'h00);
        rd(1, 0, "R9 enable reads zero");
        check("R9 no access once disabled", ram_req, 0);

        // R12 size zero
        prog(1, 8'h06, 0, 16'h2000, 0);
        wr(1, 8'h02);
        nreq = 0;
        repeat (20) begin @(negedge clk); nreq += ram_req; @(posedge clk); #1; end
        check("R12 size zero moves nothing", nreq, 0);
        wr(1, 0);

        // R3 invalid code
        prog(2, 8'h09, 0, 16'h3000, 8);
        wr(1, 8'h04);
        nreq = 0;
        repeat (20) begin @(negedge clk); nreq += ram_req; @(posedge clk); #1; end
        check("R3 invalid code moves nothing", nreq, 0);
        wr(1, 0);

        // R7 rotation among three contending channels
        prog(0, 8'h05, 0, 16'h5000, 100);
        prog(1, 8'h06, 0, 16'h6000, 100);
        prog(2, 8'h07, 0, 16'h7000, 100);
        wr(1, 8'h07);
        prevp = -1;
        repeat (9) begin
            @(negedge clk);
            curp = -1;
            for (int p = 0; p < 4; p++) if (port_ack[p]) curp = p;
            if (prevp >= 0) check("R7 round-robin rotation", curp, (prevp + 1) % 3);
            prevp = curp;
            @(posedge clk); #1;
        end
        wr(1, 0);
        port_req = '0;
        idle(2);
        for (int i = 0; i < 40; i++)
            if (mem[16'h4000 + i] === 8'(16'h4000 + i ^ 8'h40)) begin
                checks++; errors++;
                $display("FAIL R4 output not stored: actual=%0h expected=changed", mem[16'h4000 + i]);
                break;
            end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule